// File: doc/BRIEF.md
# Time-Index Weighted-Sum Accumulator

This block takes a stream of signed samples and, over each block of a fixed number of samples, produces three block sums: the plain sum of the samples, the sum of each sample weighted by its position in the block, and the sum weighted by the square of that position. The position counts up from zero within each block and starts again at zero for the next block. A downstream timing-offset estimator uses the two index-weighted sums.

No sample is ever multiplied by its index. Three running accumulators are chained, each adding the freshly updated value of the stage before it. On the last sample of a block, the three chained values are combined with three multiplications by compile-time constants and a one-bit shift, which give the weighted sums: S0 = A1, S1 = N·A1 − A2 and S2 = N²·A1 − (2N+1)·A2 + 2·A3. No sample is stored and no table of index powers is held. The results are registered and announced with a one-cycle done strobe. The accumulators restart in that same cycle, so the next block may begin on the very next sample.

A clear input drops a partly collected block at any time. The block length N and the sample width are parameters, and N must be at least 2.

Top module: `idxsum_top`

## Requirements
- R1: While reset is low at a clock edge, done_o is cleared to 0 and sum0_o, sum1_o and sum2_o are cleared to zero.
- R2: At each done pulse, sum0_o equals the sum of v[n] over the N accepted samples of the block just completed, with n = 0 for the first accepted sample.
- R3: At each done pulse, sum1_o equals the sum of n·v[n] over that block.
- R4: At each done pulse, sum2_o equals the sum of n²·v[n] over that block.
- R5: done_o is high for exactly one cycle, namely the cycle after the clock edge that accepts the N-th sample of a block. It is low at all other times.
- R6: A cycle with smp_valid low accepts no sample. It does not advance the index or change any sum, whatever value smp_data holds.
- R7: When blk_clear is high at an edge, the partial block is discarded, the index returns to 0, no done follows, and a sample presented in that same cycle is not accepted.
- R8: Blocks may follow back to back with no idle cycle. The first sample after the N-th is accepted as index 0 of the next block, and no sample is lost.
- R9: Between done pulses, sum0_o, sum1_o and sum2_o keep their last values.
- R10: No intermediate value overflows. Blocks made entirely of the most negative sample value, or entirely of the most positive one, give exact sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_clear | input | 1 | Abandons the current block and restarts the index at 0 |
| smp_valid | input | 1 | Qualifies smp_data in this cycle |
| smp_data | input | SMP_W | Signed input sample |
| sum0_o | output | SMP_W+G | Plain block sum, G = clog2(BLK_N)+1 |
| sum1_o | output | SMP_W+2G | Index-weighted block sum |
| sum2_o | output | SMP_W+3G | Index-squared-weighted block sum |
| done_o | output | 1 | One-cycle strobe marking new results |

## Verification
The bound checker keeps its own index counter and builds the three sums by multiplying each sample directly by its index. On every cycle it compares the done timing and all three results against this model. It also checks that done is a single pulse, that a clear or an idle cycle is never followed by done, and that the outputs hold between pulses. The bench scenarios cover what a per-cycle property cannot show on its own. These are exact results for chosen patterns (a ramp, constants at both extremes of the sample range, random data), the rejection of garbage data on idle cycles inside a block, a clear arriving on what would have been the last sample, and a run of three blocks with no gap between them.

// File: rtl/idxsum_pkg.sv
// Package idxsum_pkg
// Shared sizing helpers for the weighted-sum accumulator.
// Assumes a block length of at least 2.
package idxsum_pkg;

    // Number of cascaded accumulator stages (highest index power plus one)
    localparam int NUM_STAGES = 3;

    // Guard bits added per index power so that nothing overflows
    function automatic int guard_bits(input int blk_n);
        return $clog2(blk_n) + 1;
    endfunction

    // Width of the in-block index counter
    function automatic int ctr_width(input int blk_n);
        return (blk_n < 2) ? 1 : $clog2(blk_n);
    endfunction

endpackage

// File: rtl/idxsum_blk_ctr.sv
// Module idxsum_blk_ctr
// Counts accepted samples inside a block and flags the last one.
// Assumes take_i is already qualified by the clear input.
module idxsum_blk_ctr #(
    parameter  int BLK_N = 64,
    localparam int CNT_W = idxsum_pkg::ctr_width(BLK_N)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic take_i,
    output logic last_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLK_N - 1);

    logic [CNT_W-1:0] cnt_q;

    // Last sample of the block is being accepted in this cycle
    assign last_o = take_i && (cnt_q == LAST_IDX);

    // Index register: restarts on clear or after the final sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (take_i) begin
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/idxsum_acc_stage.sv
// Module idxsum_acc_stage
// One running accumulator of the cascade. Adds its input into its register
// on each enabled cycle and exposes the updated (next) value, so that the
// following stage and the end-of-block combiner see the post-update sum.
// Assumes the bus width is wide enough for the final stage value.
module idxsum_acc_stage #(
    parameter int BUS_W = 37
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart_i,
    input  logic                    en_i,
    input  logic signed [BUS_W-1:0] add_i,
    output logic signed [BUS_W-1:0] next_o
);

    logic signed [BUS_W-1:0] acc_q;

    // Updated value of this stage for the current sample
    assign next_o = acc_q + add_i;

    // Accumulator register: zeroed on restart, advanced on each sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (restart_i) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= next_o;
        end
    end

endmodule

// File: rtl/idxsum_combine.sv
// Module idxsum_combine
// Turns the three chained accumulator values into the plain,
// index-weighted and index-squared-weighted sums with three constant
// multiplications and a shift, and registers them with a done strobe.
// Assumes fire_i is high exactly when the final sample is being added.
module idxsum_combine #(
    parameter  int SMP_W = 16,
    parameter  int BLK_N = 64,
    localparam int GB    = idxsum_pkg::guard_bits(BLK_N),
    localparam int S0W   = SMP_W + GB,
    localparam int S1W   = SMP_W + 2 * GB,
    localparam int CW    = SMP_W + 3 * GB
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire_i,
    input  logic signed [CW-1:0]  a1_i,
    input  logic signed [CW-1:0]  a2_i,
    input  logic signed [CW-1:0]  a3_i,
    output logic signed [S0W-1:0] s0_o,
    output logic signed [S1W-1:0] s1_o,
    output logic signed [CW-1:0]  s2_o,
    output logic                  done_o
);

    localparam logic signed [S1W-1:0] K_LEN  = S1W'(BLK_N);
    localparam logic signed [CW-1:0]  K_SQ   = CW'(BLK_N * BLK_N);
    localparam logic signed [CW-1:0]  K_ODD  = CW'(2 * BLK_N + 1);

    logic signed [S0W-1:0] s0_d;
    logic signed [S1W-1:0] s1_d;
    logic signed [CW-1:0]  s2_d;
    logic signed [S1W-1:0] a1_lo;
    logic signed [S1W-1:0] a2_lo;

    assign a1_lo = a1_i[S1W-1:0];
    assign a2_lo = a2_i[S1W-1:0];

    // Final sums from the chained values (wrap-free: results fit their widths)
    always_comb begin
        s0_d = a1_i[S0W-1:0];
        s1_d = a1_lo * K_LEN - a2_lo;
        s2_d = a1_i * K_SQ - a2_i * K_ODD + (a3_i <<< 1);
    end

    // Result registers and strobe: loaded only at the end of a block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_o   <= '0;
            s1_o   <= '0;
            s2_o   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= fire_i;
            if (fire_i) begin
                s0_o <= s0_d;
                s1_o <= s1_d;
                s2_o <= s2_d;
            end
        end
    end

endmodule

// File: rtl/idxsum_top.sv
// Module idxsum_top
// Streaming block accumulator for the sums of v[n], n*v[n] and n^2*v[n]
// over fixed blocks of BLK_N accepted samples. A cascade of three running
// accumulators replaces any multiplication by the index. Clear wins over a
// sample presented in the same cycle. Assumes BLK_N >= 2.
module idxsum_top #(
    parameter  int SMP_W = 16,
    parameter  int BLK_N = 64,
    localparam int GB    = idxsum_pkg::guard_bits(BLK_N),
    localparam int S0W   = SMP_W + GB,
    localparam int S1W   = SMP_W + 2 * GB,
    localparam int S2W   = SMP_W + 3 * GB
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    blk_clear,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    output logic signed [S0W-1:0]   sum0_o,
    output logic signed [S1W-1:0]   sum1_o,
    output logic signed [S2W-1:0]   sum2_o,
    output logic                    done_o
);

    localparam int NST = idxsum_pkg::NUM_STAGES;

    logic take;
    logic last;
    logic restart;
    logic signed [S2W-1:0] chain [0:NST];

    // Sample acceptance and accumulator restart conditions
    assign take    = smp_valid && !blk_clear;
    assign restart = blk_clear || last;

    // Stage input: sign-extended sample
    assign chain[0] = S2W'(smp_data);

    idxsum_blk_ctr #(
        .BLK_N (BLK_N)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (blk_clear),
        .take_i  (take),
        .last_o  (last)
    );

    for (genvar j = 1; j <= NST; j++) begin : g_stage
        idxsum_acc_stage #(
            .BUS_W (S2W)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart),
            .en_i      (take),
            .add_i     (chain[j-1]),
            .next_o    (chain[j])
        );
    end

    idxsum_combine #(
        .SMP_W (SMP_W),
        .BLK_N (BLK_N)
    ) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (last),
        .a1_i   (chain[1]),
        .a2_i   (chain[2]),
        .a3_i   (chain[3]),
        .s0_o   (sum0_o),
        .s1_o   (sum1_o),
        .s2_o   (sum2_o),
        .done_o (done_o)
    );

endmodule

// File: rtl/idxsum_chk.sv
// Module idxsum_chk
// Property checker for idxsum_top. Keeps its own index count and builds the
// three sums by direct multiplication with the index, then compares the
// strobe timing and results of the design against that model.
module idxsum_chk #(
    parameter  int SMP_W = 16,
    parameter  int BLK_N = 64,
    localparam int GB    = idxsum_pkg::guard_bits(BLK_N),
    localparam int S0W   = SMP_W + GB,
    localparam int S1W   = SMP_W + 2 * GB,
    localparam int S2W   = SMP_W + 3 * GB
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    blk_clear,
    input logic                    smp_valid,
    input logic signed [SMP_W-1:0] smp_data,
    input logic signed [S0W-1:0]   sum0_o,
    input logic signed [S1W-1:0]   sum1_o,
    input logic signed [S2W-1:0]   sum2_o,
    input logic                    done_o
);

    int                 m_idx;
    logic signed [63:0] m_r0, m_r1, m_r2;
    logic signed [63:0] m_e0, m_e1, m_e2;
    logic               m_due;
    logic signed [63:0] v_x, i_x;
    logic signed [63:0] o0_x, o1_x, o2_x;
    logic               m_take;

    assign m_take = smp_valid && !blk_clear;
    assign v_x    = 64'(smp_data);
    assign i_x    = 64'(m_idx);
    assign o0_x   = 64'(sum0_o);
    assign o1_x   = 64'(sum1_o);
    assign o2_x   = 64'(sum2_o);

    // Reference model: direct index-multiplied sums
    always_ff @(posedge clk) begin
        if (!rst_n || blk_clear) begin
            m_idx <= 0;
            m_r0  <= '0;
            m_r1  <= '0;
            m_r2  <= '0;
            m_due <= 1'b0;
            if (!rst_n) begin
                m_e0 <= '0;
                m_e1 <= '0;
                m_e2 <= '0;
            end
        end else begin
            m_due <= 1'b0;
            if (m_take) begin
                if (m_idx == BLK_N - 1) begin
                    m_e0  <= m_r0 + v_x;
                    m_e1  <= m_r1 + i_x * v_x;
                    m_e2  <= m_r2 + i_x * i_x * v_x;
                    m_due <= 1'b1;
                    m_idx <= 0;
                    m_r0  <= '0;
                    m_r1  <= '0;
                    m_r2  <= '0;
                end else begin
                    m_r0  <= m_r0 + v_x;
                    m_r1  <= m_r1 + i_x * v_x;
                    m_r2  <= m_r2 + i_x * i_x * v_x;
                    m_idx <= m_idx + 1;
                end
            end
        end
    end

    // R5
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o == m_due);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    plain_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (o0_x == m_e0));

    // R3
    lin_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (o1_x == m_e1));

    // R4
    sq_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (o2_x == m_e2));

    // R7
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_clear |=> !done_o);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !done_o);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(sum0_o) && $stable(sum1_o) && $stable(sum2_o)));

endmodule

bind idxsum_top idxsum_chk #(
    .SMP_W (SMP_W),
    .BLK_N (BLK_N)
) u_idxsum_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_clear (blk_clear),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .sum0_o    (sum0_o),
    .sum1_o    (sum1_o),
    .sum2_o    (sum2_o),
    .done_o    (done_o)
);

// File: tb/test_idxsum_top.sv
// Directed bench for idxsum_top: one task per scenario, each checking itself.
module test_idxsum_top;

    localparam int CLK_PERIOD = 10;
    localparam int SW  = 12;
    localparam int BLK = 12;
    localparam int GB  = $clog2(BLK) + 1;
    localparam int W0  = SW + GB;
    localparam int W1  = SW + 2 * GB;
    localparam int W2  = SW + 3 * GB;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 blk_clear = 1'b0;
    logic                 smp_valid = 1'b0;
    logic signed [SW-1:0] smp_data = '0;
    logic signed [W0-1:0] sum0_o;
    logic signed [W1-1:0] sum1_o;
    logic signed [W2-1:0] sum2_o;
    logic                 done_o;

    int n_chk  = 0;
    int n_fail = 0;
    int blk [BLK];

    always #(CLK_PERIOD / 2) clk = ~clk;

    idxsum_top #(
        .SMP_W (SW),
        .BLK_N (BLK)
    ) i_idxsum_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_clear (blk_clear),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .sum0_o    (sum0_o),
        .sum1_o    (sum1_o),
        .sum2_o    (sum2_o),
        .done_o    (done_o)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs; returns at the following falling edge
    task automatic drive(input logic v, input logic signed [SW-1:0] d, input logic c);
        smp_valid = v;
        smp_data  = d;
        blk_clear = c;
        @(negedge clk);
    endtask

    function automatic logic signed [SW-1:0] rnd_smp();
        return SW'($urandom);
    endfunction

    task automatic fill_random();
        for (int i = 0; i < BLK; i++) blk[i] = int'(rnd_smp());
    endtask

    task automatic fill_const(input int v);
        for (int i = 0; i < BLK; i++) blk[i] = v;
    endtask

    // Compare the three results against directly multiplied reference sums
    task automatic check_block(input string tag);
        longint e0 = 0, e1 = 0, e2 = 0;
        for (int i = 0; i < BLK; i++) begin
            e0 += longint'(blk[i]);
            e1 += longint'(i) * longint'(blk[i]);
            e2 += longint'(i) * longint'(i) * longint'(blk[i]);
        end
        check({tag, " R5 done"}, longint'(done_o), 1);
        check({tag, " R2 sum0"}, longint'(sum0_o), e0);
        check({tag, " R3 sum1"}, longint'(sum1_o), e1);
        check({tag, " R4 sum2"}, longint'(sum2_o), e2);
    endtask

    // Feed blk[] with gap idle cycles before each sample, then check results
    task automatic feed_block(input string tag, input int gap);
        for (int i = 0; i < BLK; i++) begin
            for (int g = 0; g < gap; g++) begin
                drive(1'b0, rnd_smp(), 1'b0);
                check({tag, " R6 idle no done"}, longint'(done_o), 0);
            end
            drive(1'b1, SW'(blk[i]), 1'b0);
            if (i == BLK - 2)
                check({tag, " R5 no early done"}, longint'(done_o), 0);
        end
        check_block(tag);
    endtask

    task automatic t_reset();
        check("R1 done", longint'(done_o), 0);
        check("R1 sum0", longint'(sum0_o), 0);
        check("R1 sum1", longint'(sum1_o), 0);
        check("R1 sum2", longint'(sum2_o), 0);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < BLK; i++) blk[i] = i - 5;
        feed_block("ramp", 0);
        drive(1'b0, '0, 1'b0);
        check("ramp R5 pulse ends", longint'(done_o), 0);
    endtask

    task automatic t_gaps();
        fill_random();
        feed_block("gaps", 2);
    endtask

    task automatic t_clear();
        for (int i = 0; i < 5; i++) drive(1'b1, rnd_smp(), 1'b0);
        drive(1'b1, 12'sd777, 1'b1);
        check("R7 no done after clear", longint'(done_o), 0);
        fill_random();
        feed_block("clear mid", 0);
        for (int i = 0; i < BLK - 1; i++) drive(1'b1, rnd_smp(), 1'b0);
        drive(1'b1, rnd_smp(), 1'b1);
        check("R7 clear on last slot", longint'(done_o), 0);
        fill_random();
        feed_block("clear last", 0);
    endtask

    task automatic t_back_to_back();
        for (int b = 0; b < 3; b++) begin
            fill_random();
            feed_block("R8 b2b", 0);
        end
    endtask

    task automatic t_hold();
        longint h0, h1, h2;
        h0 = longint'(sum0_o);
        h1 = longint'(sum1_o);
        h2 = longint'(sum2_o);
        for (int i = 0; i < 3; i++) drive(1'b0, rnd_smp(), 1'b0);
        for (int i = 0; i < 4; i++) drive(1'b1, rnd_smp(), 1'b0);
        check("R9 hold sum0", longint'(sum0_o), h0);
        check("R9 hold sum1", longint'(sum1_o), h1);
        check("R9 hold sum2", longint'(sum2_o), h2);
        check("R9 hold done", longint'(done_o), 0);
        drive(1'b0, '0, 1'b1);
    endtask

    task automatic t_extremes();
        fill_const(-(1 <<< (SW - 1)));
        feed_block("R10 min", 0);
        fill_const((1 <<< (SW - 1)) - 1);
        feed_block("R10 max", 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ramp();
        t_gaps();
        t_clear();
        t_back_to_back();
        t_hold();
        t_extremes();
        drive(1'b0, '0, 1'b0);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule